// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a serial management master for Ethernet PHYs. It uses the two-wire style with a management clock and a bidirectional data line, and a single 32-bit frame register loads every transaction. Software writes the frame register to launch a frame. The controller then sends a preamble of 32 ones, followed by the register's start, opcode, PHY address, register address, turnaround and data fields, most significant bit first.

On a read, the controller lets go of the data line at the turnaround so the PHY can answer. It samples the 16 returned bits and writes them into the low half of the same register. Completion is marked by a sticky event flag, which software clears by writing one. The management clock comes from the system clock through a programmable half-period divider. With a 50 MHz system clock, a half period of 10 gives 2.5 MHz.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset and whenever no frame is in progress, `mdc` is low, `mdio_oe` is 0, `busy` is 0, and (after reset) `evt_done` is 0.
- R2: While a frame runs, one `mdc` period lasts 2*`div_half` system clock cycles (a value of 0 acts as 1).
- R3: The frame register layout is [31:30] start, [29:28] opcode (10 = read, 01 = write), [27:23] PHY address, [22:18] register address, [17:16] turnaround, [15:0] data. Every frame is 64 `mdc` cycles long. It carries 32 ones, then register bits 31 down to 0.
- R4: The master changes `mdio_o` only while `mdc` is low, at its falling edge. The value stays steady while `mdc` is high.
- R5: For opcode 10, the master drives the line through register-address bit 18. It releases the line (`mdio_oe`=0) for both turnaround bits and all 16 data bits, and samples `mdio_i` at each rising `mdc` edge of the data phase.
- R6: When a read frame ends, `frame_rdata[15:0]` holds the 16 sampled bits, first sampled in bit 15. Bits [31:16] keep the written value.
- R7: For any opcode other than 10 (for example 01), all 64 bits are driven, including the turnaround bits as written. `frame_rdata` is unchanged at the end of the frame.
- R8: `busy` is 1 from the cycle after an accepted write until the frame ends. A `frame_wr` while `busy` is 1 is ignored and changes neither the register nor the frame on the line.
- R9: `evt_done` sets when a frame ends and stays set until a cycle with `evt_clr`=1. A frame end in the same cycle as a clear wins, and `evt_clr` has no effect when the flag is already clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_wr | input | 1 | Write strobe for the frame register |
| frame_wdata | input | 32 | Value written to the frame register |
| evt_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| div_half | input | DIV_W | Management clock half period in system clocks |
| frame_rdata | output | 32 | Frame register contents |
| busy | output | 1 | Frame in progress |
| evt_done | output | 1 | Sticky frame completion flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The hardest case to reach is a register write that arrives in the middle of a read frame. The bench has to show that this write disturbs neither the bits on the line nor the captured data that later replaces the low half. To do this, one read frame fires an ignored write with inverted contents about a hundred cycles into the frame. A PHY responder in the bench decodes the opcode from the line and answers only on reads, starting at the second turnaround bit. The scoreboard then compares the whole 64-bit line pattern and the enable pattern seen at the rising clock edges against what the written word predicts. Running frames at divider settings of 10, 3 and 1 covers the tightest sample-to-drive spacing as well.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_W      = 32;
  localparam int FRAME_W    = 32;
  localparam int TOTAL_BITS = PRE_W + FRAME_W;
  localparam int IDX_W      = $clog2(TOTAL_BITS);
  localparam int DATA_W     = 16;
  localparam int OP_HI      = 29;
  localparam int OP_LO      = 28;
  // frame position where a read releases the line (first turnaround bit)
  localparam int REL_POS    = PRE_W + 14;
  // frame position of the first returned data bit
  localparam int CAP_POS    = PRE_W + 16;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;
  logic             mdc_q, mdc_d, wrap;

  assign lim  = (div_half == '0) ? '0 : div_half - 1'b1;
  assign wrap = run && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_evt = wrap && !mdc_q;
  assign fall_evt = wrap && mdc_q;
endmodule

// File: rtl/mdio_sequencer.sv
module mdio_sequencer
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               rd_mode,
  input  logic [FRAME_W-1:0] frame,
  input  logic               rise_evt,
  input  logic               fall_evt,
  input  logic               mdio_i,
  output logic               busy,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_BITS - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(REL_POS);
  localparam logic [IDX_W-1:0] CAP_IDX  = IDX_W'(CAP_POS);

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_nx;
  logic              out_q, out_d, oe_q, oe_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  // preamble positions carry ones; frame positions pick register bits MSB first
  function automatic logic bit_at(input logic [IDX_W-1:0] i, input logic [FRAME_W-1:0] f);
    return i[IDX_W-1] ? f[~i[IDX_W-2:0]] : 1'b1;
  endfunction

  assign idx_nx = idx_q + 1'b1;
  assign done   = busy_q && fall_evt && (idx_q == LAST_IDX);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    out_d  = out_q;
    oe_d   = oe_q;
    sh_d   = sh_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      idx_d  = '0;
      out_d  = 1'b1;
      oe_d   = 1'b1;
    end else if (busy_q && fall_evt) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
        out_d  = 1'b0;
        oe_d   = 1'b0;
      end else begin
        idx_d = idx_nx;
        out_d = bit_at(idx_nx, frame);
        oe_d  = !(rd_mode && (idx_nx >= REL_IDX));
      end
    end
    if (busy_q && rise_evt && rd_mode && (idx_q >= CAP_IDX))
      sh_d = {sh_q[DATA_W-2:0], mdio_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      out_q  <= 1'b0;
      oe_q   <= 1'b0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      out_q  <= out_d;
      oe_q   <= oe_d;
      sh_q   <= sh_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;
  assign rd_data = sh_q;
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_wr,
  input  logic [FRAME_W-1:0] frame_wdata,
  input  logic               evt_clr,
  input  logic [DIV_W-1:0]   div_half,
  output logic [FRAME_W-1:0] frame_rdata,
  output logic               busy,
  output logic               evt_done,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               evt_q, evt_d;
  logic               seq_busy, seq_done, rise_evt, fall_evt, rd_mode, accept;
  logic [DATA_W-1:0]  rd_data;

  assign rd_mode = (frame_q[OP_HI:OP_LO] == OP_READ);
  assign accept  = frame_wr && !seq_busy;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (seq_busy),
    .div_half (div_half),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .rd_mode  (rd_mode),
    .frame    (frame_q),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .busy     (seq_busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (seq_done),
    .rd_data  (rd_data)
  );

  always_comb begin
    frame_d = frame_q;
    if (accept)
      frame_d = frame_wdata;
    else if (seq_done && rd_mode)
      frame_d = {frame_q[FRAME_W-1:DATA_W], rd_data};
    evt_d = evt_q;
    if (seq_done)
      evt_d = 1'b1;
    else if (evt_clr)
      evt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      frame_q <= frame_d;
      evt_q   <= evt_d;
    end
  end

  assign frame_rdata = frame_q;
  assign busy        = seq_busy;
  assign evt_done    = evt_q;
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] frame_rdata,
  input logic        busy,
  input logic        evt_done,
  input logic        evt_clr,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r4_mdio_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  a_r8_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(frame_rdata));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done && !evt_clr) |=> evt_done);

  a_r9_set_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> evt_done);
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_rdata (frame_rdata),
  .busy        (busy),
  .evt_done    (evt_done),
  .evt_clr     (evt_clr),
  .mdc         (mdc),
  .mdio_o      (mdio_o),
  .mdio_oe     (mdio_oe)
);

// File: tb/mdio_frame_ctrl_bench.sv
module mdio_frame_ctrl_bench;
  localparam int DIV_W = 8;
  localparam time TCLK = 20ns;

  logic             clk, rst_n, frame_wr, evt_clr;
  logic [31:0]      frame_wdata, frame_rdata;
  logic [DIV_W-1:0] div_half;
  logic             busy, evt_done, mdc, mdio_o, mdio_oe;
  logic             phy_en, phy_bit;
  wire              mdio_line;

  // pull-up when nobody drives
  assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_frame_ctrl #(.DIV_W(DIV_W)) u_mdio_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
    .evt_clr(evt_clr), .div_half(div_half), .frame_rdata(frame_rdata),
    .busy(busy), .evt_done(evt_done), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [63:0] exp_wire_q[$];
  logic [63:0] exp_oe_q[$];
  logic [63:0] wacc, oacc;
  int          nb = 0;
  time         last_rise = 0, last_per = 0;
  logic [15:0] phy_val;
  bit          phy_rd = 0;

  // monitor: line value and enable at each rising mdc
  initial begin
    wacc = '0; oacc = '0;
    forever begin
      @(posedge mdc);
      last_per  = $time - last_rise;
      last_rise = $time;
      #1;
      wacc = {wacc[62:0], mdio_line};
      oacc = {oacc[62:0], mdio_oe};
      nb++;
      if (nb == 36) phy_rd = (wacc[1:0] == 2'b10);
      if (nb == 64) begin
        nb = 0;
        if (exp_wire_q.size() == 0) begin
          chk(0, "R3 unexpected frame", wacc, 64'h0);
        end else begin
          logic [63:0] ew, eo;
          ew = exp_wire_q.pop_front();
          eo = exp_oe_q.pop_front();
          chk(wacc == ew, "R3/R5/R7 line bits", wacc, ew);
          chk(oacc == eo, "R5/R7 drive enable", oacc, eo);
        end
      end
    end
  end

  // PHY responder: changes its output after falling mdc
  initial begin
    phy_en = 1'b0; phy_bit = 1'b0;
    forever begin
      @(negedge mdc);
      if (phy_rd && nb == 47) begin
        phy_en = 1'b1; phy_bit = 1'b0;
      end else if (phy_rd && nb >= 48 && nb <= 63) begin
        phy_en = 1'b1; phy_bit = phy_val[63 - nb];
      end else begin
        phy_en = 1'b0;
      end
    end
  end

  task automatic run_frame(input logic [31:0] word, input logic [15:0] pdata,
                           input logic [7:0] div, input bit poke);
    bit rd;
    logic [31:0] exp_reg;
    rd = (word[29:28] == 2'b10);
    phy_val = pdata;
    div_half = div;
    exp_wire_q.push_back(rd ? {32'hFFFF_FFFF, word[31:18], 2'b10, pdata} : {32'hFFFF_FFFF, word});
    exp_oe_q.push_back(rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF);
    exp_reg = rd ? {word[31:16], pdata} : word;
    @(negedge clk); frame_wr = 1'b1; frame_wdata = word;
    @(negedge clk); frame_wr = 1'b0;
    chk(busy == 1'b1, "R8 busy after write", 64'(busy), 64'd1);
    if (poke) begin
      repeat (100) @(negedge clk);
      frame_wr = 1'b1; frame_wdata = ~word;
      @(negedge clk); frame_wr = 1'b0;
      chk(frame_rdata == word, "R8 write during busy ignored", 64'(frame_rdata), 64'(word));
    end
    while (busy) @(negedge clk);
    chk(frame_rdata == exp_reg, rd ? "R6 read data captured" : "R7 register unchanged",
        64'(frame_rdata), 64'(exp_reg));
    chk(evt_done == 1'b1, "R9 flag set at end", 64'(evt_done), 64'd1);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
    chk(last_per == 2 * ((div == 0) ? 1 : div) * TCLK, "R2 mdc period",
        64'(last_per), 64'(2 * ((div == 0) ? 1 : div) * TCLK));
    repeat (40) @(negedge clk);
    chk(evt_done == 1'b1, "R9 flag sticky", 64'(evt_done), 64'd1);
    evt_clr = 1'b1; @(negedge clk); evt_clr = 1'b0;
    chk(evt_done == 1'b0, "R9 write one clears", 64'(evt_done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R3 frame never finished actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_wr = 1'b0; frame_wdata = '0; evt_clr = 1'b0; div_half = 8'd10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mdc == 1'b0, "R1 reset mdc low", 64'(mdc), 64'd0);
    chk(mdio_oe == 1'b0, "R1 reset released", 64'(mdio_oe), 64'd0);
    chk(busy == 1'b0, "R1 reset not busy", 64'(busy), 64'd0);
    chk(evt_done == 1'b0, "R1 reset flag clear", 64'(evt_done), 64'd0);
    evt_clr = 1'b1; @(negedge clk); evt_clr = 1'b0;
    chk(evt_done == 1'b0, "R9 clear on clear flag no effect", 64'(evt_done), 64'd0);

    // read PHY 1 reg 2 at 2.5 MHz
    run_frame({2'b01, 2'b10, 5'd1, 5'd2, 2'b10, 16'h0000}, 16'h0007, 8'd10, 1'b0);
    // write PHY 5 reg 31
    run_frame({2'b01, 2'b01, 5'd5, 5'd31, 2'b10, 16'hA5C3}, 16'h1234, 8'd3, 1'b0);
    // read with ignored mid-frame write
    run_frame({2'b01, 2'b10, 5'd17, 5'd9, 2'b10, 16'h5A5A}, 16'h8001, 8'd3, 1'b1);
    // read at fastest divider
    run_frame({2'b01, 2'b10, 5'd31, 5'd0, 2'b10, 16'hFFFF}, 16'hC3E1, 8'd1, 1'b0);
    // write with ignored mid-frame write, divider value 0 acts as 1
    run_frame({2'b01, 2'b01, 5'd0, 5'd21, 2'b10, 16'h0F0F}, 16'h0000, 8'd0, 1'b1);

    chk(exp_wire_q.size() == 0, "R3 all frames seen", 64'(exp_wire_q.size()), 64'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule